// File: doc/BRIEF.md
# Strap-Sampled Dual LED Pin Controller

This block runs two bidirectional pads of an Ethernet PHY that each serve two purposes. While reset is held, both pads are released and their pulled levels are read as configuration straps. The two straps form a two-bit PHY address. After reset the same pads become LED drivers: pad 0 shows link-good status and pad 1 shows transmit/receive activity.

The strap level read on each pad also sets that pad's LED polarity. A pad strapped high drives its LED active-low, and a pad strapped low drives it active-high. Activity pulses are stretched by a down-counter, so that short bursts stay visible for a parameterised number of clock cycles. Each strap input passes through a synchronizer before it is captured. The capture happens on every clock edge that sees reset asserted, so the value in effect is the one taken on the last such edge.

Top module: `strap_led_ctrl`

## Requirements
- R1: pad_oe is 2'b00 after every clock edge that samples rst_n low, and 2'b11 after every clock edge that samples rst_n high.
- R2: phy_addr[0] is taken from pad_in[0] (the link pad) and phy_addr[1] from pad_in[1] (the activity pad). A high level gives 1 and a low level gives 0.
- R3: The captured strap bit equals the pad level sampled SYNC_STAGES clock edges before the last edge that samples rst_n low. A pad change that is sampled only on later edges does not reach phy_addr.
- R4: phy_addr does not change on any edge that samples rst_n high, whatever pad_in does.
- R5: The LED level for each pad is "on" XOR its strap bit. A pad strapped 1 drives 0 when on and 1 when off. A pad strapped 0 drives 1 when on and 0 when off. An off LED is still driven: pad_oe stays 1.
- R6: After each edge that samples rst_n high, pad_out[0] shows the LED level for link_good as sampled on that edge.
- R7: After an edge that samples tx_active or rx_active high, pad_out[1] shows the on level. It keeps the on level for STRETCH_CYCLES further edges with no activity, and shows the off level after the next edge.
- R8: Activity sampled while the LED is already stretched restarts the full STRETCH_CYCLES count from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are sampled while it is low |
| link_good | input | 1 | Link status; 1 means the link is up |
| tx_active | input | 1 | Transmit activity strobe |
| rx_active | input | 1 | Receive activity strobe |
| pad_in | input | 2 | Pad input levels; bit 0 is the link pad, bit 1 is the activity pad |
| pad_out | output | 2 | Pad output levels, same bit order as pad_in |
| pad_oe | output | 2 | Pad output enables; 1 means the pad is driven |
| phy_addr | output | 2 | Strapped PHY address |

## Verification
A wrong strap register shows up two ways at once, right after reset. The phy_addr value is wrong, and the polarity is inverted on the first LED edge, so a single link_good toggle exposes it. A stretch counter that loads or decrements wrongly makes the activity pad go off one or more edges early or late. The bench therefore checks every edge of the stretch window, both for a single pulse and for a restarted one. An enable flop that lags or leads reset shows up on the first edge of reset or on the first edge after it. All four strap combinations are swept, and each is checked against the same pad behaviour.

// File: rtl/strap_led_pkg.sv
package strap_led_pkg;

  localparam int unsigned NUM_PADS = 2;
  localparam int unsigned LINK_PAD = 0;
  localparam int unsigned ACT_PAD  = 1;

  // LED pad level: strapped-high pads are active-low.
  function automatic logic led_level(input logic on, input logic strap_hi);
    return on ^ strap_hi;
  endfunction

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) chain[0] <= d;

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) chain[s] <= chain[s-1];
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/act_stretch.sv
module act_stretch #(
  parameter int unsigned STRETCH_CYCLES = 1 << 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_in,
  output logic act_on
);
  localparam int unsigned CW = $clog2(STRETCH_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(STRETCH_CYCLES);

  logic [CW-1:0] cnt;
  logic          cnt_live;

  assign cnt_live = (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (act_in)   cnt <= LOAD;
    else if (cnt_live) cnt <= cnt - 1'b1;
  end

  assign act_on = act_in | cnt_live;

  a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
    act_in |=> cnt == LOAD);
  a_r7_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_in && cnt_live) |=> cnt == $past(cnt) - 1'b1);
endmodule

// File: rtl/led_pin_drv.sv
module led_pin_drv
  import strap_led_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic strap_hi,
  input  logic on,
  output logic pad_out,
  output logic pad_oe
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pad_out <= 1'b0;
      pad_oe  <= 1'b0;
    end else begin
      pad_out <= led_level(on, strap_hi);
      pad_oe  <= 1'b1;
    end
  end

  a_r5_level: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (pad_out == ($past(on) ^ strap_hi)));
endmodule

// File: rtl/strap_led_ctrl.sv
module strap_led_ctrl
  import strap_led_pkg::*;
#(
  parameter int unsigned STRETCH_CYCLES = 1 << 20,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       link_good,
  input  logic       tx_active,
  input  logic       rx_active,
  input  logic [1:0] pad_in,
  output logic [1:0] pad_out,
  output logic [1:0] pad_oe,
  output logic [1:0] phy_addr
);
  logic [NUM_PADS-1:0] pad_sync;
  logic [NUM_PADS-1:0] strap_q;
  logic [NUM_PADS-1:0] led_on;
  logic                act_on;
  logic                strap_capture;

  strap_sync #(.STAGES(SYNC_STAGES), .WIDTH(NUM_PADS)) u_sync (
    .clk (clk),
    .d   (pad_in),
    .q   (pad_sync)
  );

  // Straps are re-sampled on every reset edge; the last one wins.
  assign strap_capture = !rst_n;

  always_ff @(posedge clk) begin
    if (strap_capture) strap_q <= pad_sync;
  end

  act_stretch #(.STRETCH_CYCLES(STRETCH_CYCLES)) u_stretch (
    .clk    (clk),
    .rst_n  (rst_n),
    .act_in (tx_active | rx_active),
    .act_on (act_on)
  );

  assign led_on[LINK_PAD] = link_good;
  assign led_on[ACT_PAD]  = act_on;

  generate
    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
      led_pin_drv u_drv (
        .clk      (clk),
        .rst_n    (rst_n),
        .strap_hi (strap_q[p]),
        .on       (led_on[p]),
        .pad_out  (pad_out[p]),
        .pad_oe   (pad_oe[p])
      );
    end
  endgenerate

  assign phy_addr = strap_q;

  a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(phy_addr));
  a_r1_oe_driven: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (pad_oe == 2'b11));
  a_r6_link_pad: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (pad_out[0] == (phy_addr[0] ? !$past(link_good) : $past(link_good))));
  a_r2_capture_live: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (phy_addr == $past(pad_sync)));
endmodule

// File: tb/strap_led_ctrl_tb.sv
module strap_led_ctrl_tb;
  localparam int unsigned S = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_good = 1'b0, tx_active = 1'b0, rx_active = 1'b0;
  logic [1:0] pad_in = 2'b00;
  logic [1:0] pad_out, pad_oe, phy_addr;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  strap_led_ctrl #(.STRETCH_CYCLES(S), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .link_good(link_good), .tx_active(tx_active),
    .rx_active(rx_active), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .phy_addr(phy_addr)
  );

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Expected pad level, stated arithmetically: strapped-high pads invert.
  function automatic logic want(input logic on, input logic strap);
    if (strap) return on ? 1'b0 : 1'b1;
    else       return on ? 1'b1 : 1'b0;
  endfunction

  task automatic do_reset(input logic [1:0] strap, input bit late);
    rst_n = 1'b0;
    pad_in = strap;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R1 oe in reset", pad_oe, 2'b00);
    end
    if (late) pad_in = ~strap;  // sampled only on the last reset edge: R3
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 oe after reset", pad_oe, 2'b11);
    check(late ? "R3 late change ignored" : "R2 addr capture", phy_addr, strap);
    pad_in = strap;
  endtask

  task automatic act_window(input logic [1:0] strap, input string req);
    for (int k = 0; k < S; k++) begin
      @(negedge clk);
      check(req, {1'b0, pad_out[1]}, {1'b0, want(1'b1, strap[1])});
    end
    @(negedge clk);
    check({req, " off"}, {1'b0, pad_out[1]}, {1'b0, want(1'b0, strap[1])});
    check("R5 off still driven", pad_oe, 2'b11);
  endtask

  initial begin
    for (int sv = 0; sv < 4; sv++) begin
      logic [1:0] st;
      st = 2'(sv);
      do_reset(st, 1'b0);
      check("R5 idle act level", {1'b0, pad_out[1]}, {1'b0, want(1'b0, st[1])});
      for (int l = 0; l < 2; l++) begin
        link_good = l[0];
        @(negedge clk);
        check("R6 R5 link level", {1'b0, pad_out[0]}, {1'b0, want(l[0], st[0])});
      end
      link_good = 1'b0;
      @(negedge clk);
      check("R6 link off", {1'b0, pad_out[0]}, {1'b0, want(1'b0, st[0])});
      // tx single-cycle pulse
      tx_active = 1'b1;
      @(negedge clk);
      tx_active = 1'b0;
      check("R7 tx on", {1'b0, pad_out[1]}, {1'b0, want(1'b1, st[1])});
      act_window(st, "R7 tx stretch");
      // rx pulse, then restart midway
      rx_active = 1'b1;
      @(negedge clk);
      rx_active = 1'b0;
      check("R7 rx on", {1'b0, pad_out[1]}, {1'b0, want(1'b1, st[1])});
      repeat (3) @(negedge clk);
      tx_active = 1'b1;
      @(negedge clk);
      tx_active = 1'b0;
      act_window(st, "R8 restart stretch");
      // straps moving after reset must not reach phy_addr
      for (int p = 0; p < 4; p++) begin
        pad_in = 2'(p);
        repeat (4) @(negedge clk);
        check("R4 addr stable", phy_addr, st);
      end
    end
    do_reset(2'b10, 1'b1);
    do_reset(2'b01, 1'b1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule